// File: doc/BRIEF.md
# Prescaled Timer with Clear-on-Match and Event Capture

A 16-bit up-counter advances on ticks from a prescaler whose divide ratio is a power of two, set by a select input. In free-running mode the counter wraps from its maximum value to zero and raises an overflow request. In clear-on-match mode it returns to zero on the tick after it equals a compare value, so the period is the compare value plus one ticks. A toggle enable makes an output inverts on every match, which gives a square wave whose frequency follows the compare value.

An external event line passes through a two-flop synchronizer. Each rising edge on the synchronized line stores the running count in a capture register. Three sticky request flags (overflow, match, capture) stay set until a write-one-to-clear strobe removes them.

Top module: `tick_timer16`

## Requirements
- R1: While reset is held and right after it, count, capture, wave_out and all three request flags are zero.
- R2: With div_sel = k, the counter advances once every 2^k clocks. N clocks after reset is released, the count is floor(N / 2^k) (free-running mode, before the first wrap).
- R3: In free-running mode the count wraps from 0xFFFF to 0, and irq_ovf sets on that tick.
- R4: In clear-on-match mode, a tick that finds count equal to cmp_val loads zero, giving a period of cmp_val+1 ticks. With cmp_val = 0 the count stays at zero.
- R5: With toggle_en high, wave_out inverts on every tick at which count equals cmp_val, in either mode.
- R6: A rising edge on evt_in loads into capture the count held two clocks after that edge and sets irq_cap. An input that stays high produces only one capture.
- R7: irq_match sets on every tick at which count equals cmp_val, in both modes. In clear-on-match mode with cmp_val = 0xFFFF, the return to zero sets irq_match and does not set irq_ovf.
- R8: The flags are sticky. flag_clr bit 0 clears irq_ovf, bit 1 clears irq_match and bit 2 clears irq_cap. When a flag is set and cleared in the same clock, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Prescaler select, divide by 2^div_sel |
| clr_on_match | input | 1 | 1: clear-on-match mode, 0: free-running mode |
| toggle_en | input | 1 | Invert wave_out on each compare match |
| cmp_val | input | 16 | Compare value |
| evt_in | input | 1 | Asynchronous event line |
| flag_clr | input | 3 | Write-one-to-clear strobes {cap, match, ovf} |
| count | output | 16 | Current counter value |
| capture | output | 16 | Last captured count |
| wave_out | output | 1 | Toggle output |
| irq_ovf | output | 1 | Overflow request flag |
| irq_match | output | 1 | Compare-match request flag |
| irq_cap | output | 1 | Capture request flag |

## Verification
The hardest cases to reach are the full-range ones. These are the wrap from 0xFFFF in free-running mode and the clear at a compare value of 0xFFFF, where the overflow flag must stay low. The bench runs the counter at divide-by-one for more than 65,536 clocks in each mode to reach them. A capture that collides with a clear strobe in the same clock is set up by timing the strobe from the known two-clock synchronizer delay.

// File: rtl/tick_timer16.sv
module tick_timer16 #(
  parameter int WIDTH = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             clr_on_match,
  input  logic             toggle_en,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic             evt_in,
  input  logic [2:0]       flag_clr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capture,
  output logic             wave_out,
  output logic             irq_ovf,
  output logic             irq_match,
  output logic             irq_cap
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic             tick;
  logic             match_ev, clear_ev, ovf_ev;
  logic             evt_s1, evt_s2, evt_d;
  logic             cap_rise;

  assign pre_mask = ~({PRE_W{1'b1}} << div_sel);
  assign tick     = (pre_cnt & pre_mask) == pre_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;

  assign match_ev = tick && (count == cmp_val);
  assign clear_ev = match_ev && clr_on_match;
  assign ovf_ev   = tick && (count == CNT_MAX) && !clear_ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        count <= '0;
    else if (clear_ev) count <= '0;
    else if (tick)     count <= count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     wave_out <= 1'b0;
    else if (match_ev && toggle_en) wave_out <= ~wave_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {evt_s1, evt_s2, evt_d} <= '0;
    else        {evt_s1, evt_s2, evt_d} <= {evt_in, evt_s1, evt_s2};

  assign cap_rise = evt_s2 && !evt_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        capture <= '0;
    else if (cap_rise) capture <= count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_ovf   <= 1'b0;
      irq_match <= 1'b0;
      irq_cap   <= 1'b0;
    end else begin
      irq_ovf   <= (irq_ovf   && !flag_clr[0]) || ovf_ev;
      irq_match <= (irq_match && !flag_clr[1]) || match_ev;
      irq_cap   <= (irq_cap   && !flag_clr[2]) || cap_rise;
    end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r3_free_run_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_on_match) |=> count == $past(count) + 1'b1);
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_match && tick && count == cmp_val) |=> count == '0);
  a_r5_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && toggle_en) |=> wave_out != $past(wave_out));
  a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> (capture == $past(count)) && irq_cap);
  a_r7_no_ovf_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ev && !irq_ovf) |=> !irq_ovf);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !flag_clr[0]) |=> irq_ovf);
  a_r8_match_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_match && !flag_clr[1]) |=> irq_match);
endmodule

// File: tb/tick_timer16_bench.sv
`timescale 1ns/1ps
module tick_timer16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = '0;
  logic        clr_on_match = 1'b0;
  logic        toggle_en = 1'b0;
  logic [15:0] cmp_val = '0;
  logic        evt_in = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic [15:0] count, capture;
  logic        wave_out, irq_ovf, irq_match, irq_cap;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tick_timer16 u_tick_timer16 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .clr_on_match(clr_on_match),
    .toggle_en(toggle_en), .cmp_val(cmp_val), .evt_in(evt_in), .flag_clr(flag_clr),
    .count(count), .capture(capture), .wave_out(wave_out),
    .irq_ovf(irq_ovf), .irq_match(irq_match), .irq_cap(irq_cap));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [2:0] sel, input logic ctc, input logic tog,
                         input logic [15:0] cmp);
    @(negedge clk);
    rst_n = 1'b0;
    div_sel = sel; clr_on_match = ctc; toggle_en = tog; cmp_val = cmp;
    evt_in = 1'b0; flag_clr = '0;
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cmps[5] = '{0, 1, 2, 5, 13};
    logic [15:0] c0;
    restart(3'd0, 1'b0, 1'b1, 16'd0);
    // R1 reset state
    rst_n = 1'b0;
    step();
    check("R1 count", count, 0);
    check("R1 capture", capture, 0);
    check("R1 flags", {wave_out, irq_ovf, irq_match, irq_cap}, 0);
    rst_n = 1'b1;

    // R2 prescaler sweep
    for (int k = 0; k < 8; k++) begin
      restart(3'(k), 1'b0, 1'b0, 16'hFFFF);
      for (int n = 1; n <= 300; n++) begin
        step();
        if (n % 50 == 0) check("R2 prescaled count", count, 32'(n >> k));
      end
    end

    // R4 R5 R7 clear-on-match sweep
    for (int k = 0; k < 3; k++)
      for (int ci = 0; ci < 5; ci++) begin
        restart(3'(k), 1'b1, 1'b1, 16'(cmps[ci]));
        for (int n = 1; n <= 200; n++) begin
          int t;
          step();
          t = n >> k;
          check("R4 ctc count", count, 32'(t % (cmps[ci] + 1)));
          check("R5 toggle wave", wave_out, 32'((t / (cmps[ci] + 1)) & 1));
          if (n % 40 == 0) begin
            check("R7 match flag", irq_match, 32'(t >= cmps[ci] + 1));
            check("R3 no ovf in ctc", irq_ovf, 0);
          end
        end
      end

    // R3 R7 free-running wrap with match at 100
    restart(3'd0, 1'b0, 1'b1, 16'd100);
    repeat (100) step();
    check("R7 no match yet", irq_match, 0);
    step();
    check("R7 match in free mode", irq_match, 1);
    check("R5 wave free mode", wave_out, 1);
    repeat (65535 - 101) step();
    check("R3 count at max", count, 16'hFFFF);
    check("R3 ovf before wrap", irq_ovf, 0);
    step();
    check("R3 wrap count", count, 0);
    check("R3 ovf set", irq_ovf, 1);
    // R8 clear overflow and match with strobes
    flag_clr = 3'b011;
    step();
    flag_clr = 3'b000;
    check("R8 ovf cleared", irq_ovf, 0);
    check("R8 match cleared", irq_match, 0);
    step();
    check("R8 stays clear", {irq_ovf, irq_match}, 0);

    // R7 ctc at 0xFFFF: no overflow
    restart(3'd0, 1'b1, 1'b0, 16'hFFFF);
    repeat (65535) step();
    check("R7 count at max", count, 16'hFFFF);
    check("R7 match before", irq_match, 0);
    step();
    check("R7 cleared to zero", count, 0);
    check("R7 match on clear", irq_match, 1);
    check("R7 no ovf on clear", irq_ovf, 0);

    // R6 capture
    restart(3'd0, 1'b0, 1'b0, 16'hFFFF);
    repeat (37) step();
    c0 = count;
    evt_in = 1'b1;
    step(); step();
    check("R6 not yet captured", irq_cap, 0);
    step();
    check("R6 capture value", capture, 32'(c0 + 16'd2));
    check("R6 capture flag", irq_cap, 1);
    repeat (10) step();
    check("R6 single capture while high", capture, 32'(c0 + 16'd2));
    flag_clr = 3'b100;
    step();
    flag_clr = 3'b000;
    check("R8 cap cleared", irq_cap, 0);
    // R8 set wins over clear in the same clock
    evt_in = 1'b0;
    repeat (5) step();
    c0 = count;
    evt_in = 1'b1;
    step(); step();
    flag_clr = 3'b100;
    step();
    flag_clr = 3'b000;
    check("R8 set wins", irq_cap, 1);
    check("R6 second capture", capture, 32'(c0 + 16'd2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule